// File: doc/BRIEF.md
# Disk Track Sector Framer

This block keeps time along one recorded track of a moving-head cartridge drive and frames the bits that pass under the head. A sector counter follows the per-sector timing pulses. The once-per-revolution index pulse arrives during the final sector of the track, so the counter restarts at zero on the sector pulse that follows it. A track holds twelve sectors by default.

On the write side, a single request sends one complete sector as a bit stream, most significant bit first, one bit for each bit-clock enable. The stream has six fields: a run of zero bits that ends in a single one bit, which is the sync mark; a header word holding the cylinder and the sector number; the data words, fetched one at a time from an external buffer through an index output; a checksum word; and one closing word of zeros. The preamble is fifteen words long, sync bit included, and there are 256 data words.

On the read side, an arm request starts a search for the sync mark: the first one bit that follows at least 64 consecutive zero bits. After the sync mark, the block rebuilds the header and the data words, presents each with a one-cycle strobe, and compares the received checksum against its own sum of the data words. A host buffer fills from the word strobes.

Top module: `trk_sector_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, sector_num is 0, tx_active and tx_bit are 0, rx_hunting is 0, and no strobe output is high.
- R2: Each sector_pulse with no index pending adds one to sector_num. The value after SECTORS-1 is 0, and sector_num changes on no other cycle.
- R3: An index_pulse leaves sector_num unchanged and makes the next sector_pulse load 0. When index_pulse and sector_pulse arrive in the same cycle, the count advances as usual and the following sector_pulse loads 0.
- R4: The cycle after wr_start is sampled, tx_active goes high. tx_bit then shows the following stream, MSB first: 14 zero words, the word 0x0001 (its last bit is the sync one), the header, 256 data words, the checksum and one zero word. Only a cycle with bit_en high moves to the next bit; otherwise tx_bit holds. While tx_active is low, tx_bit is 0.
- R5: Header bits 15:13 are zero, bits 12:4 hold wr_cyl and bits 3:0 hold sector_num. Both values are captured in the cycle wr_start is taken, so later sector pulses do not alter them.
- R6: The checksum word is the sum of the 256 data words modulo 65536.
- R7: While data word k is due, wr_idx equals k, and wr_word is sampled in that cycle.
- R8: In the cycle after the final bit is consumed, tx_active is 0 and tx_done pulses for one cycle. A wr_start while tx_active is high is ignored.
- R9: After rx_arm, a one bit counts as sync only if at least 64 zero bits came just before it. A one bit after a shorter run restarts the zero count. rx_hunting is high from arming until sync is found.
- R10: After sync, rx_hdr_valid pulses once with the header in rx_hdr. rx_word_valid then pulses once for each data word, with rx_word_idx counting up from 0.
- R11: After the checksum word, rx_done pulses and rx_csum_err shows whether that word differed from the sum of the received data words. rx_arm is ignored while a sector is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable; one bit moves per high cycle |
| sector_pulse | input | 1 | Start of a sector |
| index_pulse | input | 1 | Marks the last sector of the track |
| sector_num | output | 4 | Current sector number |
| wr_start | input | 1 | Request to write one sector |
| wr_cyl | input | 9 | Cylinder number for the header |
| wr_idx | output | 8 | Index of the data word being fetched |
| wr_word | input | 16 | Data word from the buffer at wr_idx |
| tx_bit | output | 1 | Serial write data |
| tx_active | output | 1 | A sector is being sent |
| tx_done | output | 1 | One-cycle pulse at the end of a sent sector |
| rx_arm | input | 1 | Start searching for sync |
| rx_bit | input | 1 | Serial read data |
| rx_hunting | output | 1 | Searching for sync |
| rx_hdr | output | 16 | Received header word |
| rx_hdr_valid | output | 1 | rx_hdr updated this cycle |
| rx_word | output | 16 | Received data word |
| rx_word_valid | output | 1 | rx_word updated this cycle |
| rx_word_idx | output | 8 | Index of rx_word |
| rx_done | output | 1 | Checksum word received |
| rx_csum_err | output | 1 | Checksum mismatch in the last sector read |

## Verification
Two functions can fall in the same clock cycle. The first is the sector count: the index marking and the sector advance can both occur in one cycle. The bench drives index_pulse and sector_pulse on the same edge and then checks that sector_num steps normally on that pulse and returns to 0 on the next one. The second is framing while the counter moves: a sector pulse arrives during the preamble of a write, and new wr_start and rx_arm requests arrive in the middle of the data field. The bench compares every transmitted bit, the header's captured sector field and the looped-back words against its own model of the sector.

// File: rtl/trk_pkg.sv
package trk_pkg;

    localparam int WORD_W    = 16;
    localparam int HDR_SEC_W = 4;
    localparam int HDR_CYL_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        FLD_PRE,
        FLD_SYNC,
        FLD_HDR,
        FLD_DATA,
        FLD_CSUM,
        FLD_POST
    } field_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HUNT,
        RX_RECV
    } rx_state_e;

    typedef struct packed {
        logic       busy;
        logic [3:0] bitcnt;
    } tx_ctl_t;

    // Field kind of word n inside a sector whose preamble is pre words
    // (the last of them carrying the sync bit) and which has data words.
    function automatic field_e field_of(input int unsigned n,
                                        input int unsigned pre,
                                        input int unsigned data);
        if (n + 1 < pre)            return FLD_PRE;
        else if (n + 1 == pre)      return FLD_SYNC;
        else if (n == pre)          return FLD_HDR;
        else if (n <= pre + data)   return FLD_DATA;
        else if (n == pre + data + 1) return FLD_CSUM;
        else                        return FLD_POST;
    endfunction

    function automatic word_t make_header(input logic [HDR_CYL_W-1:0] cyl,
                                          input logic [HDR_SEC_W-1:0] sec);
        return {{(WORD_W-HDR_CYL_W-HDR_SEC_W){1'b0}}, cyl, sec};
    endfunction

endpackage

// File: rtl/trk_sector_count.sv
module trk_sector_count
    import trk_pkg::*;
#(
    parameter int SECTORS = 12,
    parameter int SEC_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sector_pulse,
    input  logic             index_pulse,
    output logic [SEC_W-1:0] sector_num
);

    logic wrap_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            sector_num   <= '0;
            wrap_pending <= 1'b0;
        end else if (sector_pulse) begin
            if (wrap_pending || sector_num == SEC_W'(SECTORS-1))
                sector_num <= '0;
            else
                sector_num <= sector_num + 1'b1;
            // an index seen with this pulse tags the sector now starting
            wrap_pending <= index_pulse;
        end else if (index_pulse) begin
            wrap_pending <= 1'b1;
        end
    end

endmodule

// File: rtl/trk_sector_writer.sv
module trk_sector_writer
    import trk_pkg::*;
#(
    parameter int PRE_WORDS  = 15,
    parameter int DATA_WORDS = 256,
    parameter int SEC_W      = 4,
    parameter int IDX_W      = 8,
    parameter int NW_W       = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic                 wr_start,
    input  logic [HDR_CYL_W-1:0] wr_cyl,
    input  logic [SEC_W-1:0]     sector_num,
    input  word_t                wr_word,
    output logic [IDX_W-1:0]     wr_idx,
    output logic                 tx_bit,
    output logic                 tx_active,
    output logic                 tx_done
);

    localparam int TOTAL = PRE_WORDS + DATA_WORDS + 3;

    tx_ctl_t         ctl;
    word_t           shreg;
    word_t           sum;
    word_t           hdr_q;
    word_t           next_word;
    logic [NW_W-1:0] nw;
    field_e          nf;

    assign nf        = field_of(32'(nw), PRE_WORDS, DATA_WORDS);
    assign wr_idx    = IDX_W'(nw - NW_W'(PRE_WORDS + 1));
    assign tx_bit    = ctl.busy & shreg[WORD_W-1];
    assign tx_active = ctl.busy;

    always_comb begin
        case (nf)
            FLD_SYNC: next_word = word_t'(1);
            FLD_HDR:  next_word = hdr_q;
            FLD_DATA: next_word = wr_word;
            FLD_CSUM: next_word = sum;
            default:  next_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            shreg   <= '0;
            sum     <= '0;
            hdr_q   <= '0;
            nw      <= '0;
            tx_done <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            if (!ctl.busy) begin
                if (wr_start) begin
                    ctl.busy   <= 1'b1;
                    ctl.bitcnt <= '0;
                    shreg      <= '0;
                    sum        <= '0;
                    nw         <= NW_W'(1);
                    hdr_q      <= make_header(wr_cyl, HDR_SEC_W'(sector_num));
                end
            end else if (bit_en) begin
                if (ctl.bitcnt == 4'd15) begin
                    ctl.bitcnt <= '0;
                    if (nw == NW_W'(TOTAL)) begin
                        ctl.busy <= 1'b0;
                        tx_done  <= 1'b1;
                        shreg    <= '0;
                    end else begin
                        shreg <= next_word;
                        nw    <= nw + 1'b1;
                        if (nf == FLD_DATA)
                            sum <= sum + wr_word;
                    end
                end else begin
                    ctl.bitcnt <= ctl.bitcnt + 1'b1;
                    shreg      <= {shreg[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/trk_sector_reader.sv
module trk_sector_reader
    import trk_pkg::*;
#(
    parameter int DATA_WORDS = 256,
    parameter int MIN_ZEROS  = 64,
    parameter int IDX_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             rx_arm,
    input  logic             rx_bit,
    output logic             rx_hunting,
    output word_t            rx_hdr,
    output logic             rx_hdr_valid,
    output word_t            rx_word,
    output logic             rx_word_valid,
    output logic [IDX_W-1:0] rx_word_idx,
    output logic             rx_done,
    output logic             rx_csum_err
);

    localparam int ZC_W = $clog2(MIN_ZEROS + 1);
    localparam int RW_W = $clog2(DATA_WORDS + 2);

    rx_state_e       st;
    logic [ZC_W-1:0] zc;
    logic [3:0]      bitcnt;
    logic [RW_W-1:0] rw;
    word_t           shin;
    word_t           sum;
    word_t           got;

    assign got        = {shin[WORD_W-2:0], rx_bit};
    assign rx_hunting = (st == RX_HUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= RX_IDLE;
            zc            <= '0;
            bitcnt        <= '0;
            rw            <= '0;
            shin          <= '0;
            sum           <= '0;
            rx_hdr        <= '0;
            rx_hdr_valid  <= 1'b0;
            rx_word       <= '0;
            rx_word_valid <= 1'b0;
            rx_word_idx   <= '0;
            rx_done       <= 1'b0;
            rx_csum_err   <= 1'b0;
        end else begin
            rx_hdr_valid  <= 1'b0;
            rx_word_valid <= 1'b0;
            rx_done       <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (rx_arm) begin
                        st <= RX_HUNT;
                        zc <= '0;
                    end
                end
                RX_HUNT: begin
                    if (bit_en) begin
                        if (!rx_bit) begin
                            if (zc != ZC_W'(MIN_ZEROS))
                                zc <= zc + 1'b1;
                        end else if (zc == ZC_W'(MIN_ZEROS)) begin
                            st     <= RX_RECV;
                            bitcnt <= '0;
                            rw     <= '0;
                            sum    <= '0;
                        end else begin
                            zc <= '0;
                        end
                    end
                end
                default: begin
                    if (bit_en) begin
                        shin <= got;
                        if (bitcnt == 4'd15) begin
                            bitcnt <= '0;
                            rw     <= rw + 1'b1;
                            if (rw == '0) begin
                                rx_hdr       <= got;
                                rx_hdr_valid <= 1'b1;
                            end else if (rw <= RW_W'(DATA_WORDS)) begin
                                rx_word       <= got;
                                rx_word_valid <= 1'b1;
                                rx_word_idx   <= IDX_W'(rw - 1'b1);
                                sum           <= sum + got;
                            end else begin
                                rx_done     <= 1'b1;
                                rx_csum_err <= (got != sum);
                                st          <= RX_IDLE;
                            end
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/trk_sector_framer.sv
module trk_sector_framer
    import trk_pkg::*;
#(
    parameter int SECTORS    = 12,
    parameter int PRE_WORDS  = 15,
    parameter int DATA_WORDS = 256,
    parameter int MIN_ZEROS  = 64,
    localparam int SEC_W     = $clog2(SECTORS),
    localparam int IDX_W     = $clog2(DATA_WORDS),
    localparam int NW_W      = $clog2(PRE_WORDS + DATA_WORDS + 4)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic                 sector_pulse,
    input  logic                 index_pulse,
    output logic [SEC_W-1:0]     sector_num,
    input  logic                 wr_start,
    input  logic [HDR_CYL_W-1:0] wr_cyl,
    output logic [IDX_W-1:0]     wr_idx,
    input  logic [WORD_W-1:0]    wr_word,
    output logic                 tx_bit,
    output logic                 tx_active,
    output logic                 tx_done,
    input  logic                 rx_arm,
    input  logic                 rx_bit,
    output logic                 rx_hunting,
    output logic [WORD_W-1:0]    rx_hdr,
    output logic                 rx_hdr_valid,
    output logic [WORD_W-1:0]    rx_word,
    output logic                 rx_word_valid,
    output logic [IDX_W-1:0]     rx_word_idx,
    output logic                 rx_done,
    output logic                 rx_csum_err
);

    trk_sector_count #(
        .SECTORS (SECTORS),
        .SEC_W   (SEC_W)
    ) u_count (
        .clk          (clk),
        .rst          (rst),
        .sector_pulse (sector_pulse),
        .index_pulse  (index_pulse),
        .sector_num   (sector_num)
    );

    trk_sector_writer #(
        .PRE_WORDS  (PRE_WORDS),
        .DATA_WORDS (DATA_WORDS),
        .SEC_W      (SEC_W),
        .IDX_W      (IDX_W),
        .NW_W       (NW_W)
    ) u_writer (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .wr_start   (wr_start),
        .wr_cyl     (wr_cyl),
        .sector_num (sector_num),
        .wr_word    (wr_word),
        .wr_idx     (wr_idx),
        .tx_bit     (tx_bit),
        .tx_active  (tx_active),
        .tx_done    (tx_done)
    );

    trk_sector_reader #(
        .DATA_WORDS (DATA_WORDS),
        .MIN_ZEROS  (MIN_ZEROS),
        .IDX_W      (IDX_W)
    ) u_reader (
        .clk           (clk),
        .rst           (rst),
        .bit_en        (bit_en),
        .rx_arm        (rx_arm),
        .rx_bit        (rx_bit),
        .rx_hunting    (rx_hunting),
        .rx_hdr        (rx_hdr),
        .rx_hdr_valid  (rx_hdr_valid),
        .rx_word       (rx_word),
        .rx_word_valid (rx_word_valid),
        .rx_word_idx   (rx_word_idx),
        .rx_done       (rx_done),
        .rx_csum_err   (rx_csum_err)
    );

endmodule

// File: rtl/trk_framer_chk.sv
module trk_framer_chk #(
    parameter int SECTORS = 12,
    parameter int SEC_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_en,
    input logic             sector_pulse,
    input logic [SEC_W-1:0] sector_num,
    input logic             wr_start,
    input logic             tx_bit,
    input logic             tx_active,
    input logic             tx_done,
    input logic             rx_hunting,
    input logic             rx_hdr_valid,
    input logic             rx_word_valid,
    input logic             rx_done
);

    // R2
    sector_range_chk: assert property (@(posedge clk) disable iff (rst)
        sector_num <= SEC_W'(SECTORS-1));

    // R2
    sector_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(sector_pulse) |-> $stable(sector_num));

    // R4
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_active |-> !tx_bit);

    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_active && $past(tx_active) && !$past(bit_en)) |-> $stable(tx_bit));

    // R8
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_active) |-> $past(wr_start));

    // R8
    end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_active) |-> tx_done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> !tx_active);

    // R10
    rx_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_hdr_valid || rx_word_valid || rx_done) |-> !rx_hunting);

    // R11
    rx_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_hdr_valid, rx_word_valid, rx_done}));

endmodule

bind trk_sector_framer trk_framer_chk #(
    .SECTORS (SECTORS),
    .SEC_W   (SEC_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bit_en        (bit_en),
    .sector_pulse  (sector_pulse),
    .sector_num    (sector_num),
    .wr_start      (wr_start),
    .tx_bit        (tx_bit),
    .tx_active     (tx_active),
    .tx_done       (tx_done),
    .rx_hunting    (rx_hunting),
    .rx_hdr_valid  (rx_hdr_valid),
    .rx_word_valid (rx_word_valid),
    .rx_done       (rx_done)
);

// File: tb/trk_sector_framer_test.sv
module trk_sector_framer_test;

    localparam int PRE   = 15;
    localparam int DW    = 256;
    localparam int TOTAL = PRE + DW + 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        sector_pulse = 1'b0;
    logic        index_pulse = 1'b0;
    logic [3:0]  sector_num;
    logic        wr_start = 1'b0;
    logic [8:0]  wr_cyl = '0;
    logic [7:0]  wr_idx;
    logic [15:0] wr_word;
    logic        tx_bit, tx_active, tx_done;
    logic        rx_arm = 1'b0;
    logic        rx_bit;
    logic        rx_hunting;
    logic [15:0] rx_hdr, rx_word;
    logic        rx_hdr_valid, rx_word_valid, rx_done, rx_csum_err;
    logic [7:0]  rx_word_idx;

    logic        loop_sel = 1'b1;
    logic        flip = 1'b0;
    logic        rx_drv = 1'b0;
    logic [15:0] dbuf [DW];

    always #4 clk = ~clk;

    assign wr_word = dbuf[wr_idx];
    assign rx_bit  = loop_sel ? (tx_bit ^ flip) : rx_drv;

    trk_sector_framer uut (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .sector_pulse(sector_pulse), .index_pulse(index_pulse),
        .sector_num(sector_num),
        .wr_start(wr_start), .wr_cyl(wr_cyl), .wr_idx(wr_idx), .wr_word(wr_word),
        .tx_bit(tx_bit), .tx_active(tx_active), .tx_done(tx_done),
        .rx_arm(rx_arm), .rx_bit(rx_bit), .rx_hunting(rx_hunting),
        .rx_hdr(rx_hdr), .rx_hdr_valid(rx_hdr_valid),
        .rx_word(rx_word), .rx_word_valid(rx_word_valid), .rx_word_idx(rx_word_idx),
        .rx_done(rx_done), .rx_csum_err(rx_csum_err)
    );

    int errors = 0;
    int checks = 0;

    int          hdr_cnt, word_cnt, order_err, data_err, done_cnt, txdone_cnt;
    logic [15:0] hdr_val;
    logic        err_val;

    always @(negedge clk) begin
        if (rx_hdr_valid) begin
            hdr_cnt++;
            hdr_val = rx_hdr;
        end
        if (rx_word_valid) begin
            if (32'(rx_word_idx) != word_cnt) order_err++;
            if (rx_word !== dbuf[rx_word_idx]) data_err++;
            word_cnt++;
        end
        if (rx_done) begin
            done_cnt++;
            err_val = rx_csum_err;
        end
        if (tx_done) txdone_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        hdr_cnt = 0; word_cnt = 0; order_err = 0; data_err = 0;
        done_cnt = 0; txdone_cnt = 0; hdr_val = '0; err_val = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse(input bit sp, input bit ip);
        @(negedge clk);
        sector_pulse = sp;
        index_pulse  = ip;
        @(negedge clk);
        sector_pulse = 1'b0;
        index_pulse  = 1'b0;
    endtask

    task automatic test_reset();
        do_reset();
        chk(sector_num == 4'd0, "R1", "sector_num", sector_num, 0);
        chk(!tx_active && !tx_bit, "R1", "tx idle", {tx_active, tx_bit}, 0);
        chk(!rx_hunting, "R1", "rx_hunting", rx_hunting, 0);
        chk(!rx_hdr_valid && !rx_word_valid && !rx_done && !tx_done, "R1", "strobes",
            {rx_hdr_valid, rx_word_valid, rx_done, tx_done}, 0);
    endtask

    task automatic test_sector_wrap();
        int bad = 0;
        do_reset();
        for (int i = 1; i <= 13; i++) begin
            pulse(1'b1, 1'b0);
            if (32'(sector_num) != i % 12) bad++;
        end
        chk(bad == 0, "R2", "count and wrap mismatches", bad, 0);
        chk(sector_num == 4'd1, "R2", "value after 13 pulses", sector_num, 1);
    endtask

    task automatic test_index();
        do_reset();
        repeat (4) pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        chk(sector_num == 4'd4, "R3", "index alone keeps count", sector_num, 4);
        pulse(1'b1, 1'b0);
        chk(sector_num == 4'd0, "R3", "pulse after index", sector_num, 0);
        repeat (3) pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        chk(sector_num == 4'd4, "R3", "coincident pulses advance", sector_num, 4);
        pulse(1'b1, 1'b0);
        chk(sector_num == 4'd0, "R3", "pulse after coincident", sector_num, 0);
        pulse(1'b1, 1'b0);
        chk(sector_num == 4'd1, "R3", "pending cleared", sector_num, 1);
    endtask

    task automatic run_sector(input logic [8:0] cyl, input bit gaps,
                              input int flip_at, input bit pokes);
        logic [15:0] sum = '0;
        logic [15:0] hdr;
        logic [15:0] w;
        logic        v;
        int e_frame = 0, e_hdr = 0, e_dat = 0, e_cs = 0, e_hold = 0;
        for (int i = 0; i < DW; i++) sum = sum + dbuf[i];
        @(posedge clk);
        clear_mon();
        @(negedge clk);
        hdr = {3'b000, cyl, sector_num};
        loop_sel = 1'b1;
        wr_cyl   = cyl;
        wr_start = 1'b1;
        rx_arm   = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        rx_arm   = 1'b0;
        chk(tx_active, "R4", "tx_active after start", tx_active, 1);
        for (int n = 0; n < TOTAL; n++) begin
            if (n < PRE - 1)         w = 16'h0000;
            else if (n == PRE - 1)   w = 16'h0001;
            else if (n == PRE)       w = hdr;
            else if (n <= PRE + DW)  w = dbuf[n - PRE - 1];
            else if (n == PRE+DW+1)  w = sum;
            else                     w = 16'h0000;
            for (int b = 15; b >= 0; b--) begin
                int gi = n * 16 + (15 - b);
                if (gaps && (gi % 3 == 0)) begin
                    bit_en = 1'b0;
                    v = tx_bit;
                    @(posedge clk);
                    @(negedge clk);
                    if (tx_bit !== v) e_hold++;
                end
                if (pokes && gi == 100) sector_pulse = 1'b1;
                if (pokes && gi == 2000) begin
                    wr_start = 1'b1;
                    rx_arm   = 1'b1;
                end
                bit_en = 1'b1;
                flip   = (gi == flip_at);
                if (tx_bit !== w[b]) begin
                    if (n == PRE) e_hdr++;
                    else if (n > PRE && n <= PRE + DW) e_dat++;
                    else if (n == PRE + DW + 1) e_cs++;
                    else e_frame++;
                end
                @(posedge clk);
                @(negedge clk);
                bit_en = 1'b0;
                flip = 1'b0;
                sector_pulse = 1'b0;
                wr_start = 1'b0;
                rx_arm = 1'b0;
            end
        end
        chk(!tx_active, "R8", "tx_active after last bit", tx_active, 0);
        chk(tx_done, "R8", "tx_done after last bit", tx_done, 1);
        repeat (3) @(negedge clk);
        chk(e_frame == 0, "R4", "preamble/sync/postamble bit errors", e_frame, 0);
        chk(e_dat == 0, "R7", "data field bit errors", e_dat, 0);
        chk(e_hdr == 0, "R5", "header bit errors", e_hdr, 0);
        chk(e_cs == 0, "R6", "checksum bit errors", e_cs, 0);
        if (gaps) chk(e_hold == 0, "R4", "bit changed without enable", e_hold, 0);
        chk(txdone_cnt == 1, "R8", "tx_done count", txdone_cnt, 1);
        chk(hdr_cnt == 1 && hdr_val == hdr, "R10", "received header", hdr_val, hdr);
        chk(word_cnt == DW && order_err == 0, "R10", "word count/order",
            word_cnt, DW);
        if (flip_at < 0)
            chk(data_err == 0, "R10", "received data mismatches", data_err, 0);
        chk(done_cnt == 1, "R11", "rx_done count", done_cnt, 1);
        chk(err_val == (flip_at >= 0), "R11", "checksum error flag", err_val,
            (flip_at >= 0));
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_drv = b;
        bit_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic test_hunt();
        logic [15:0] h = 16'hA5C3;
        do_reset();
        loop_sel = 1'b0;
        clear_mon();
        @(negedge clk);
        rx_arm = 1'b1;
        @(negedge clk);
        rx_arm = 1'b0;
        chk(rx_hunting, "R9", "hunting after arm", rx_hunting, 1);
        repeat (10) send_bit(1'b0);
        send_bit(1'b1);
        chk(rx_hunting, "R9", "one after 10 zeros not sync", rx_hunting, 1);
        repeat (63) send_bit(1'b0);
        send_bit(1'b1);
        chk(rx_hunting, "R9", "one after 63 zeros not sync", rx_hunting, 1);
        repeat (64) send_bit(1'b0);
        chk(rx_hunting, "R9", "still hunting before one", rx_hunting, 1);
        send_bit(1'b1);
        chk(!rx_hunting, "R9", "one after 64 zeros is sync", rx_hunting, 0);
        for (int b = 15; b >= 0; b--) send_bit(h[b]);
        @(negedge clk);
        chk(hdr_cnt == 1 && hdr_val == h, "R9", "word after sync", hdr_val, h);
        loop_sel = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DW; i++) dbuf[i] = 16'(i * 32'h2F1D + 32'h9C4B);
        test_reset();
        test_sector_wrap();
        test_index();
        repeat (4) pulse(1'b1, 1'b0);   // sector 5
        run_sector(9'h1A5, 1'b0, -1, 1'b0);
        for (int i = 0; i < DW; i++) dbuf[i] = ~dbuf[i] ^ 16'(i);
        run_sector(9'h0FF, 1'b1, -1, 1'b1);   // R5 latch, R8/R11 ignored requests
        run_sector(9'h003, 1'b0, (PRE + 1 + 3) * 16 + 5, 1'b0);
        test_hunt();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule